// File: doc/BRIEF.md
# Flash Operation Completion Poller

This block sits on the host side of a byte-wide flash device. Once an embedded program or erase operation has been kicked off elsewhere, the poller is started with the address to watch and the byte that was meant to be written. It then issues status reads over a simple synchronous read port and inspects three status bits: bit 7 (data-polling flag), bit 6 (toggle flag) and bit 5 (timeout flag). It reports a one-cycle `done` pulse together with a held `pass` or `fail` verdict.

There are two detection methods, chosen per operation by `modeToggle`. In data-polling mode the block waits for bit 7 of the status to equal bit 7 of the expected byte. For an erase the caller supplies an expected byte with bit 7 set, and may poll any address in the sector being erased. In toggle mode the block waits for two consecutive reads to return the same bit 6. In both modes a raised bit 5 does not fail the operation at once. The block first re-reads: once in data-polling mode, twice in toggle mode. This keeps a completion that lands at the same time as the timeout from being reported as a failure. An optional read-count limit ends a run that never converges with a fail.

Top module: `flash_done_poller`

## Requirements
- R1: After reset, `busy`, `rdReq`, `done`, `pass` and `fail` are all 0.
- R2: A `start` seen while `busy` is 0 is accepted. On the next cycle `busy` and `rdReq` are 1, `rdAddr` equals the `startAddr` given with it, and `pass` and `fail` are both 0. A `start` seen while `busy` is 1 is ignored: address, mode and expected byte keep their accepted values.
- R3: `rdReq` stays high for the whole of a run. A read completes in each cycle where `rdReq` and `rdReady` are both 1. `rdData` is only used in such a cycle, and `rdAddr` does not change while a read is pending.
- R4: In data-polling mode (`modeToggle`=0, sampled at start), a completed read whose bit 7 equals bit 7 of `expData` ends the run with pass, even when bit 5 of the same read is 1.
- R5: In data-polling mode, a read with a bit 7 mismatch and bit 5 = 1 causes exactly one more read. That read ends the run with pass if its bit 7 matches, otherwise with fail.
- R6: In data-polling mode, a read with a bit 7 mismatch and bit 5 = 0 leads to another read.
- R7: In toggle mode (`modeToggle`=1), the first read of a run never ends the run. A later read whose bit 6 equals bit 6 of the previous completed read ends the run with pass.
- R8: In toggle mode, a read whose bit 6 differs from the previous read and whose bit 5 = 1 causes exactly two further reads. The run ends with pass if bit 6 is equal across those two reads, otherwise with fail.
- R9: With `MAX_POLLS` nonzero, a read that would otherwise lead to another ordinary poll ends the run with fail when it is read number `MAX_POLLS` of the run. With `MAX_POLLS` = 0 there is no limit.
- R10: `done` is high for exactly one cycle, the cycle after the deciding read completes. In that same cycle `busy` falls and exactly one of `pass`/`fail` is 1. That verdict holds until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a run (ignored while busy) |
| startAddr | input | AW | Address to poll |
| expData | input | 8 | Byte intended to be written (bit 7 used) |
| modeToggle | input | 1 | 0 = data polling, 1 = toggle polling |
| rdAddr | output | AW | Status read address |
| rdReq | output | 1 | Status read request |
| rdData | input | 8 | Status byte, valid with rdReady |
| rdReady | input | 1 | Read completes this cycle |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| pass | output | 1 | Operation completed successfully |
| fail | output | 1 | Operation timed out or hit the poll limit |

## Verification
Two events can fall in the same cycle, and both are provoked on purpose.

The first is a new `start` arriving in the very cycle the `done` pulse of the previous run is high. The bench drives it back to back with no idle cycle between runs. It then judges on every clock that the old verdict is visible exactly for that one cycle, that it is cleared on the next cycle and that the new address appears.

The second is a single status byte that carries both the completion match and the timeout bit. The bench requires the completion to win and give pass, with no re-read taken.

// File: rtl/fpoll_pkg.sv
package fpoll_pkg;

  // Where the run currently stands in its status-read sequence.
  typedef enum logic [1:0] {
    PH_FIRST = 2'd0,  // toggle mode: reference read, no decision
    PH_WATCH = 2'd1,  // ordinary polling
    PH_CHK1  = 2'd2,  // toggle mode: first read after timeout flag
    PH_CHK2  = 2'd3   // final read after timeout flag
  } phase_e;

  // Strobes from control to datapath.
  typedef struct packed {
    logic load;      // capture start parameters, clear verdict
    logic savePrev;  // remember bit 6 of this read
    logic bump;      // count a completed read
    logic finish;    // end run
    logic verdict;   // 1 = pass, valid with finish
  } strobe_t;

endpackage

// File: rtl/fpoll_dp.sv
module fpoll_dp
  import fpoll_pkg::*;
#(
  parameter int AW        = 16,
  parameter int MAX_POLLS = 1024
) (
  input  logic          clk,
  input  logic          rstN,
  input  strobe_t       st,
  input  logic [AW-1:0] startAddr,
  input  logic [7:0]    expData,
  input  logic          modeToggle,
  input  logic [7:0]    rdData,
  output logic [AW-1:0] rdAddr,
  output logic          modeQ,
  output logic          match7,
  output logic          same6,
  output logic          errBit,
  output logic          limitHit,
  output logic          done,
  output logic          pass,
  output logic          fail
);

  localparam int CNT_W = (MAX_POLLS < 2) ? 1 : $clog2(MAX_POLLS + 1);

  logic [AW-1:0]    addrQ;
  logic             exp7Q;
  logic             prev6Q;
  logic [CNT_W-1:0] cntQ;
  logic             doneQ, passQ, failQ;

  // Status bits 4..0 and expected bits 6..0 carry no meaning here.
  logic unusedBits;
  assign unusedBits = ^{rdData[4:0], expData[6:0]};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ  <= '0;
      exp7Q  <= 1'b0;
      modeQ  <= 1'b0;
      prev6Q <= 1'b0;
      cntQ   <= '0;
      doneQ  <= 1'b0;
      passQ  <= 1'b0;
      failQ  <= 1'b0;
    end else begin
      doneQ <= st.finish;
      if (st.load) begin
        addrQ <= startAddr;
        exp7Q <= expData[7];
        modeQ <= modeToggle;
        cntQ  <= '0;
        passQ <= 1'b0;
        failQ <= 1'b0;
      end
      if (st.savePrev) prev6Q <= rdData[6];
      if (st.bump)     cntQ   <= cntQ + 1'b1;
      if (st.finish) begin
        passQ <= st.verdict;
        failQ <= !st.verdict;
      end
    end
  end

  assign match7 = (rdData[7] == exp7Q);
  assign same6  = (rdData[6] == prev6Q);
  assign errBit = rdData[5];

  generate
    if (MAX_POLLS == 0) begin : g_nolimit
      logic unusedCnt;
      assign unusedCnt = ^cntQ;
      assign limitHit  = 1'b0;
    end else begin : g_limit
      assign limitHit = (cntQ == CNT_W'(MAX_POLLS - 1));
    end
  endgenerate

  assign rdAddr = addrQ;
  assign done   = doneQ;
  assign pass   = passQ;
  assign fail   = failQ;

endmodule

// File: rtl/fpoll_ctrl.sv
module fpoll_ctrl
  import fpoll_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    start,
  input  logic    modeToggle,
  input  logic    rdReady,
  input  logic    modeQ,
  input  logic    match7,
  input  logic    same6,
  input  logic    errBit,
  input  logic    limitHit,
  output strobe_t st,
  output logic    busy
);

  logic   busyQ, busyD;
  phase_e phaseQ, phaseD;
  logic   hit;

  // Completion test for the current mode.
  assign hit = modeQ ? same6 : match7;

  always_comb begin
    st     = '0;
    busyD  = busyQ;
    phaseD = phaseQ;
    if (!busyQ) begin
      if (start) begin
        st.load = 1'b1;
        busyD   = 1'b1;
        phaseD  = modeToggle ? PH_FIRST : PH_WATCH;
      end
    end else if (rdReady) begin
      st.bump = 1'b1;
      unique case (phaseQ)
        PH_FIRST: begin
          st.savePrev = 1'b1;
          phaseD      = PH_WATCH;
          if (limitHit) begin
            st.finish = 1'b1;
            busyD     = 1'b0;
          end
        end
        PH_WATCH: begin
          st.savePrev = 1'b1;
          if (hit) begin
            st.finish  = 1'b1;
            st.verdict = 1'b1;
            busyD      = 1'b0;
          end else if (errBit) begin
            phaseD = modeQ ? PH_CHK1 : PH_CHK2;
          end else if (limitHit) begin
            st.finish = 1'b1;
            busyD     = 1'b0;
          end
        end
        PH_CHK1: begin
          st.savePrev = 1'b1;
          phaseD      = PH_CHK2;
        end
        PH_CHK2: begin
          st.finish  = 1'b1;
          st.verdict = hit;
          busyD      = 1'b0;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busyQ  <= 1'b0;
      phaseQ <= PH_WATCH;
    end else begin
      busyQ  <= busyD;
      phaseQ <= phaseD;
    end
  end

  assign busy = busyQ;

endmodule

// File: rtl/flash_done_poller.sv
module flash_done_poller
  import fpoll_pkg::*;
#(
  parameter int AW        = 16,
  parameter int MAX_POLLS = 1024
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          start,
  input  logic [AW-1:0] startAddr,
  input  logic [7:0]    expData,
  input  logic          modeToggle,
  output logic [AW-1:0] rdAddr,
  output logic          rdReq,
  input  logic [7:0]    rdData,
  input  logic          rdReady,
  output logic          busy,
  output logic          done,
  output logic          pass,
  output logic          fail
);

  strobe_t st;
  logic    modeQ, match7, same6, errBit, limitHit;

  fpoll_ctrl ctrl_i (
    .clk       (clk),
    .rstN      (rstN),
    .start     (start),
    .modeToggle(modeToggle),
    .rdReady   (rdReady),
    .modeQ     (modeQ),
    .match7    (match7),
    .same6     (same6),
    .errBit    (errBit),
    .limitHit  (limitHit),
    .st        (st),
    .busy      (busy)
  );

  fpoll_dp #(.AW(AW), .MAX_POLLS(MAX_POLLS)) dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .st        (st),
    .startAddr (startAddr),
    .expData   (expData),
    .modeToggle(modeToggle),
    .rdData    (rdData),
    .rdAddr    (rdAddr),
    .modeQ     (modeQ),
    .match7    (match7),
    .same6     (same6),
    .errBit    (errBit),
    .limitHit  (limitHit),
    .done      (done),
    .pass      (pass),
    .fail      (fail)
  );

  assign rdReq = busy;

endmodule

// File: rtl/fpoll_checker.sv
module fpoll_checker #(
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rstN,
  input logic          start,
  input logic          busy,
  input logic          done,
  input logic          pass,
  input logic          fail,
  input logic          rdReq,
  input logic          rdReady,
  input logic [AW-1:0] rdAddr
);

  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  p_done_verdict_r10: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (!busy && (pass != fail)));

  p_no_dual_verdict_r10: assert property (@(posedge clk) disable iff (!rstN)
    !(pass && fail));

  p_verdict_held_r10: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !start) |=> ($stable(pass) && $stable(fail)));

  p_accept_r2: assert property (@(posedge clk) disable iff (!rstN)
    (start && !busy) |=> (busy && !pass && !fail));

  p_req_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    (rdReq && !rdReady) |=> rdReq);

  p_addr_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    (rdReq && !rdReady) |=> $stable(rdAddr));

endmodule

bind flash_done_poller fpoll_checker #(.AW(AW)) chk_i (
  .clk    (clk),
  .rstN   (rstN),
  .start  (start),
  .busy   (busy),
  .done   (done),
  .pass   (pass),
  .fail   (fail),
  .rdReq  (rdReq),
  .rdReady(rdReady),
  .rdAddr (rdAddr)
);

// File: tb/flash_done_poller_tb_top.sv
`timescale 1ns/1ps
module flash_done_poller_tb_top;

  localparam int AW   = 12;
  localparam int MAXP = 6;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          start = 1'b0;
  logic [AW-1:0] startAddr = '0;
  logic [7:0]    expData = '0;
  logic          modeToggle = 1'b0;
  logic [AW-1:0] rdAddr;
  logic          rdReq;
  logic [7:0]    rdData = 8'hFF;
  logic          rdReady = 1'b0;
  logic          busy, done, pass, fail;

  always #10 clk = ~clk;  // 50 MHz

  flash_done_poller #(.AW(AW), .MAX_POLLS(MAXP)) dut_i (
    .clk(clk), .rstN(rstN), .start(start), .startAddr(startAddr),
    .expData(expData), .modeToggle(modeToggle), .rdAddr(rdAddr),
    .rdReq(rdReq), .rdData(rdData), .rdReady(rdReady), .busy(busy),
    .done(done), .pass(pass), .fail(fail)
  );

  int    checks = 0;
  int    failures = 0;
  string curReq = "R1";

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  bit            mBusy, mDone, mPass, mFail, mMode, mExp7, mPrev;
  int            mPhase;   // 0 first, 1 watch, 2 recheck-a, 3 recheck-b
  int            mReads;
  logic [AW-1:0] mAddr;

  always @(posedge clk) begin
    bit endRun, verdict, hit;
    endRun = 0; verdict = 0;
    mDone = 0;
    if (!rstN) begin
      mBusy = 0; mPass = 0; mFail = 0; mMode = 0; mExp7 = 0;
      mPrev = 0; mPhase = 1; mReads = 0; mAddr = '0;
    end else if (!mBusy) begin
      if (start) begin
        mBusy = 1; mAddr = startAddr; mExp7 = expData[7]; mMode = modeToggle;
        mPass = 0; mFail = 0; mReads = 0; mPhase = modeToggle ? 0 : 1;
      end
    end else if (rdReady) begin
      mReads++;
      hit = mMode ? (rdData[6] == mPrev) : (rdData[7] == mExp7);
      if (mPhase == 0) begin
        mPhase = 1;
        if (mReads >= MAXP) endRun = 1;
      end else if (mPhase == 1) begin
        if (hit) begin endRun = 1; verdict = 1; end
        else if (rdData[5]) mPhase = mMode ? 2 : 3;
        else if (mReads >= MAXP) endRun = 1;
      end else if (mPhase == 2) begin
        mPhase = 3;
      end else begin
        endRun = 1; verdict = hit;
      end
      mPrev = rdData[6];
      if (endRun) begin
        mBusy = 0; mDone = 1; mPass = verdict; mFail = !verdict;
      end
    end
  end

  // Compare on every clock, away from the active edge.
  always @(negedge clk) begin
    if (rstN) begin
      check(busy == mBusy, "R2 busy", busy, mBusy);
      check(rdReq == mBusy, "R3 rdReq", rdReq, mBusy);
      check(rdAddr == mAddr, "R2 rdAddr", rdAddr, mAddr);
      check(done == mDone, "R10 done", done, mDone);
      check(pass == mPass, {curReq, " pass"}, pass, mPass);
      check(fail == mFail, {curReq, " fail"}, fail, mFail);
    end
  end

  // ---------------- watchdog ----------------
  int cycles = 0;
  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 20000);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, failures);
      $finish;
    end
  end

  // ---------------- stimulus ----------------
  task automatic runCase(input string req, input bit mode, input logic [AW-1:0] a,
                         input logic [7:0] e, input logic [7:0] bytes[$],
                         input bit expPass, input bit intrude);
    int guard = 0;
    curReq = req;
    start = 1; startAddr = a; expData = e; modeToggle = mode;
    @(negedge clk);
    start = 0; startAddr = ~a; expData = ~e; modeToggle = ~mode;
    foreach (bytes[i]) begin
      for (int g = 0; g < i % 3; g++) begin
        rdReady = 0; rdData = 8'hFF;
        if (intrude && i == 1) begin start = 1; startAddr = a ^ 12'h5A5; end
        @(negedge clk);
        start = 0;
      end
      rdReady = 1; rdData = bytes[i];
      @(negedge clk);
      rdReady = 0; rdData = 8'hFF;
    end
    while (busy && guard < 50) begin guard++; @(negedge clk); end
    check(pass == expPass, {req, " verdict pass"}, pass, expPass);
    check(fail == !expPass, {req, " verdict fail"}, fail, !expPass);
    if (intrude) check(rdAddr == a, "R2 ignored start", rdAddr, a);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(!busy && !rdReq && !done && !pass && !fail, "R1 reset state",
          {busy, rdReq, done, pass, fail}, 0);
    rstN = 1;
    @(negedge clk);
    check(!busy && !done && !pass && !fail, "R1 after release",
          {busy, done, pass, fail}, 0);

    // R4: data polling, match after a few reads; gaps test R3
    runCase("R4", 0, 12'h123, 8'h80, '{8'h00, 8'h00, 8'h80}, 1, 0);
    repeat (2) @(negedge clk);
    // R4: match and timeout flag in the same read -> pass
    runCase("R4", 0, 12'h0F0, 8'hC3, '{8'hA0}, 1, 0);
    repeat (2) @(negedge clk);
    // R5: timeout flag then matching re-read
    runCase("R5", 0, 12'h200, 8'h80, '{8'h00, 8'h20, 8'h80}, 1, 0);
    repeat (2) @(negedge clk);
    // R5: timeout flag then still mismatched
    runCase("R5", 0, 12'h201, 8'h80, '{8'h20, 8'h00}, 0, 0);
    repeat (2) @(negedge clk);
    // R6: program of a byte with bit 7 clear
    runCase("R6", 0, 12'h3FF, 8'h11, '{8'h80, 8'h80, 8'h00}, 1, 0);
    repeat (2) @(negedge clk);
    // R7: toggle mode, stops toggling on the fourth read
    runCase("R7", 1, 12'h444, 8'h00, '{8'h40, 8'h00, 8'h40, 8'h40}, 1, 0);
    repeat (2) @(negedge clk);
    // R7: first read carries the timeout flag but decides nothing
    runCase("R7", 1, 12'h445, 8'h00, '{8'h60, 8'h60}, 1, 0);
    repeat (2) @(negedge clk);
    // R8: timeout flag in toggle mode, then stable bit 6 -> pass
    runCase("R8", 1, 12'h500, 8'h00, '{8'h40, 8'h20, 8'h40, 8'h40}, 1, 0);
    repeat (2) @(negedge clk);
    // R8: timeout flag in toggle mode, still toggling -> fail
    runCase("R8", 1, 12'h501, 8'h00, '{8'h00, 8'h60, 8'h40, 8'h00}, 0, 0);
    repeat (2) @(negedge clk);
    // R9: data polling never converges, limit of MAXP reads
    runCase("R9", 0, 12'h600, 8'h80, '{8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00}, 0, 0);
    repeat (2) @(negedge clk);
    // R9: toggle mode never settles
    runCase("R9", 1, 12'h601, 8'h00, '{8'h00, 8'h40, 8'h00, 8'h40, 8'h00, 8'h40}, 0, 0);
    repeat (2) @(negedge clk);
    // R2: start pulsed mid-run is ignored
    runCase("R2", 0, 12'h777, 8'h80, '{8'h00, 8'h00, 8'h80}, 1, 1);
    // R10: next start in the cycle done is high (no idle gap)
    check(done == 1'b1, "R10 done visible at restart", done, 1);
    runCase("R10", 1, 12'h888, 8'h00, '{8'h00, 8'h00}, 1, 0);
    repeat (2) @(negedge clk);
    check(!done && pass && !fail, "R10 verdict held", {done, pass, fail}, 3'b010);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, failures);
    $finish;
  end

endmodule